// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Set-Associative Data Cache

This block is a write-back, write-allocate data cache with several ways per set. The set is chosen from address bits that lie entirely inside the page offset. The tag arrays can therefore be read from the virtual address while a TLB, outside this block, translates the virtual page number in the same cycle. The physical tag is formed from the frame number returned by the TLB, plus any page-offset bits above the index. It is compared with the stored tag of every way in the selected set. Because the index bits never change under translation, the cache behaves like a physically indexed cache and two virtual pages that map to one frame share the same lines.

A processor presents a word request: a virtual word address, a read/write flag, write data and byte enables. It holds that request stable until a one-cycle response pulse arrives. While translation is pending the block signals busy. A translation fault ends the access with an error and leaves the cache untouched. A miss first writes back a dirty victim to the lower level, then reads the whole line, and merges any write data into that line. The response follows in the cycle after the line is installed. The victim is chosen by least-recently-used age counters, or by a pseudo-random sequence when a parameter selects that variant. An invalid way is always chosen first.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid and `rsp_valid`, `mem_req` and `req_busy` are low; the first access to any address misses.
- R2: While `req_valid` is high and the TLB reports neither `tlb_ready` nor `tlb_fault`, `req_busy` is high, no response is given and no memory request is made.
- R3: When `tlb_fault` is high for an accepted request, the response comes one cycle later with `rsp_err` = 1, no memory traffic occurs, and no line, tag, dirty bit or data word changes.
- R4: A hit responds in the cycle after acceptance (`rsp_valid` for exactly one cycle) with no memory request; a read returns the stored word.
- R5: Hits compare the physical tag: two virtual pages translated to the same frame hit the same line.
- R6: The set is address bits [11:6] (line address modulo 64 sets); up to 4 lines with equal set and different tags are resident together.
- R7: A write hit updates only the bytes whose enables are set (bit b of `req_be` covers data bits 8b+7..8b) and causes no memory write.
- R8: A miss whose victim is dirty first writes the victim's full line to its old physical line address (`mem_we` = 1), then reads the new line; a clean or invalid victim causes no write.
- R9: A write miss allocates: the line is read from memory, the enabled bytes are merged into it, and the untouched bytes keep memory's contents.
- R10: With the LRU variant, a miss in a full set replaces the way least recently hit or filled.
- R11: On a miss, `rsp_valid` rises in the cycle right after the memory acknowledges the line read, and `mem_addr`/`mem_we` stay stable while a request waits for acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present, held until response |
| req_we | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 30 ([31:2]) | Virtual word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| req_busy | output | 1 | Request cannot complete this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response carries a translation fault |
| rsp_rdata | output | 32 | Read word, or merged word for writes |
| tlb_lookup | output | 1 | Translation wanted this cycle |
| tlb_vpn | output | 20 | Virtual page number to translate |
| tlb_ready | input | 1 | Translation valid this cycle |
| tlb_fault | input | 1 | Translation failed this cycle |
| tlb_pfn | input | 20 | Physical frame number |
| mem_req | output | 1 | Lower-level request, held until acknowledged |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 26 | Physical line address |
| mem_wdata | output | 512 | Victim line data |
| mem_ack | input | 1 | Lower level completes the request this cycle |
| mem_rdata | input | 512 | Line read data, valid with `mem_ack` |

## Verification
Hits and faults answer at the first clock edge after the request meets a ready or failed translation. The bench drives at the falling edge and expects `rsp_valid` at the very next falling edge, a latency of one. A miss answers one edge after the acknowledge of the line read. The bench's memory model records the cycle in which it raised that acknowledge and checks that the response is seen exactly one cycle later. Write-back and read counts from the memory model are compared before and after each access, so the order and number of lower-level transfers per miss are checked as well as the data.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_FILL = 2'd2,
      ST_RESP = 2'd3
   } vipt_state_e;
endpackage

// File: rtl/vipt_way_match.sv
module vipt_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int WAY_W = $clog2(WAYS)
)(
   input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
   input  logic [WAYS-1:0]            set_valid,
   input  logic [TAG_W-1:0]           look_tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = set_valid[w] && (set_tags[w] == look_tag);
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (eq[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel #(
   parameter int WAYS    = 4,
   parameter int SETS    = 64,
   parameter bit USE_LRU = 1'b1,
   localparam int WAY_W = $clog2(WAYS),
   localparam int IDX_W = $clog2(SETS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] q_set,
   input  logic [WAYS-1:0]  q_valid,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim
);
   logic             free_found;
   logic [WAY_W-1:0] free_way;

   always_comb begin
      free_found = 1'b0;
      free_way   = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!q_valid[w] && !free_found) begin
            free_found = 1'b1;
            free_way   = WAY_W'(w);
         end
      end
   end

   if (USE_LRU) begin : g_lru
      logic [WAY_W-1:0] age_q [SETS][WAYS];
      logic [WAY_W-1:0] oldest;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < WAYS; w++)
                  age_q[s][w] <= WAY_W'(w);
         end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == touch_way)
                  age_q[touch_set][w] <= '0;
               else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                  age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
         end
      end

      always_comb begin
         oldest = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (age_q[q_set][w] == WAY_W'(WAYS-1)) oldest = WAY_W'(w);
         end
      end

      assign victim = free_found ? free_way : oldest;
   end else begin : g_rand
      logic [15:0] lfsr_q;
      logic        unused_touch;

      always_ff @(posedge clk) begin
         if (!rst_n) lfsr_q <= 16'hACE1;
         else        lfsr_q <= {lfsr_q[14:0],
                                lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      end

      assign unused_touch = touch_en ^ (^touch_set) ^ (^touch_way) ^ (^q_set);
      assign victim = free_found ? free_way : lfsr_q[WAY_W-1:0];
   end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
   import vipt_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PAGE_BITS  = 12,
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   parameter int LINE_BYTES = 64,
   parameter int WORD_W     = 32,
   parameter bit USE_LRU    = 1'b1
)(
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    req_valid,
   input  logic                                    req_we,
   input  logic [VA_W-1:$clog2(WORD_W/8)]          req_vaddr,
   input  logic [WORD_W-1:0]                       req_wdata,
   input  logic [WORD_W/8-1:0]                     req_be,
   output logic                                    req_busy,
   output logic                                    rsp_valid,
   output logic                                    rsp_err,
   output logic [WORD_W-1:0]                       rsp_rdata,
   output logic                                    tlb_lookup,
   output logic [VA_W-PAGE_BITS-1:0]               tlb_vpn,
   input  logic                                    tlb_ready,
   input  logic                                    tlb_fault,
   input  logic [PA_W-PAGE_BITS-1:0]               tlb_pfn,
   output logic                                    mem_req,
   output logic                                    mem_we,
   output logic [PA_W-$clog2(LINE_BYTES)-1:0]      mem_addr,
   output logic [LINE_BYTES*8-1:0]                 mem_wdata,
   input  logic                                    mem_ack,
   input  logic [LINE_BYTES*8-1:0]                 mem_rdata
);
   localparam int BE_W   = WORD_W / 8;
   localparam int BOFF_W = $clog2(BE_W);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int TAG_W  = PA_W - IDX_W - OFF_W;
   localparam int PFN_W  = PA_W - PAGE_BITS;
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int WPL    = LINE_BYTES / BE_W;
   localparam int WSEL_W = $clog2(WPL);
   localparam int LA_W   = PA_W - OFF_W;

   // elaboration-time parameter checks
   if (SETS * LINE_BYTES > (1 << PAGE_BITS)) begin : g_bad_way
      $error("one way must fit inside a page");
   end
   if ((1 << IDX_W) != SETS || (1 << OFF_W) != LINE_BYTES || (1 << WAY_W) != WAYS) begin : g_bad_pow2
      $error("sets, line bytes and ways must be powers of two");
   end
   if (WAYS < 2 || WPL < 2) begin : g_bad_small
      $error("need at least two ways and two words per line");
   end

   vipt_state_e state_q;

   logic [LINE_W-1:0] data_q  [WAYS][SETS];
   logic [TAG_W-1:0]  tag_q   [WAYS][SETS];
   logic [SETS-1:0]   valid_q [WAYS];
   logic [SETS-1:0]   dirty_q [WAYS];

   logic [IDX_W-1:0]  m_set;
   logic [TAG_W-1:0]  m_tag, m_vtag;
   logic [WAY_W-1:0]  m_way;
   logic [WSEL_W-1:0] m_word;
   logic              m_we;
   logic [WORD_W-1:0] m_wdata;
   logic [BE_W-1:0]   m_be;
   logic              err_q;
   logic [WORD_W-1:0] rdata_q;

   logic [IDX_W-1:0]             set_idx;
   logic [WSEL_W-1:0]            word_sel;
   logic [TAG_W-1:0]             look_tag;
   logic [WAYS-1:0][TAG_W-1:0]   set_tags;
   logic [WAYS-1:0]              set_valid;
   logic                         hit;
   logic [WAY_W-1:0]             hit_way;
   logic [WAY_W-1:0]             victim;
   logic                         accept;
   logic                         touch_en;
   logic [IDX_W-1:0]             touch_set;
   logic [WAY_W-1:0]             touch_way;
   logic [LINE_W-1:0]            hit_line, fill_line;

   function automatic logic [LINE_W-1:0] merge_line(input logic [LINE_W-1:0] base,
                                                    input logic [WSEL_W-1:0] ws,
                                                    input logic [WORD_W-1:0] wd,
                                                    input logic [BE_W-1:0]   be);
      logic [LINE_W-1:0] r;
      r = base;
      for (int b = 0; b < BE_W; b++) begin
         if (be[b]) r[int'(ws)*WORD_W + b*8 +: 8] = wd[b*8 +: 8];
      end
      return r;
   endfunction

   assign set_idx  = req_vaddr[OFF_W +: IDX_W];
   assign word_sel = req_vaddr[BOFF_W +: WSEL_W];
   assign tlb_vpn  = req_vaddr[VA_W-1:PAGE_BITS];

   // physical tag: frame number, plus page-offset bits above the index if a way is smaller than a page
   if (TAG_W == PFN_W) begin : g_tag_pfn
      assign look_tag = tlb_pfn;
   end else begin : g_tag_ext
      assign look_tag = {tlb_pfn, req_vaddr[PAGE_BITS-1:IDX_W+OFF_W]};
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_setrd
      assign set_tags[w]  = tag_q[w][set_idx];
      assign set_valid[w] = valid_q[w][set_idx];
   end

   vipt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .set_tags (set_tags),
      .set_valid(set_valid),
      .look_tag (look_tag),
      .hit      (hit),
      .hit_way  (hit_way)
   );

   vipt_victim_sel #(.WAYS(WAYS), .SETS(SETS), .USE_LRU(USE_LRU)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .q_set    (set_idx),
      .q_valid  (set_valid),
      .touch_en (touch_en),
      .touch_set(touch_set),
      .touch_way(touch_way),
      .victim   (victim)
   );

   assign accept    = (state_q == ST_IDLE) && req_valid && (tlb_ready || tlb_fault);
   assign hit_line  = merge_line(data_q[hit_way][set_idx], word_sel, req_wdata,
                                 req_we ? req_be : '0);
   assign fill_line = merge_line(mem_rdata, m_word, m_wdata, m_we ? m_be : '0);

   always_comb begin
      touch_en  = 1'b0;
      touch_set = set_idx;
      touch_way = hit_way;
      if (accept && !tlb_fault && hit) begin
         touch_en = 1'b1;
      end else if (state_q == ST_FILL && mem_ack) begin
         touch_en  = 1'b1;
         touch_set = m_set;
         touch_way = m_way;
      end
   end

   // data and tag arrays: no reset, validity lives in valid_q
   always_ff @(posedge clk) begin
      if (accept && !tlb_fault && hit && req_we) begin
         data_q[hit_way][set_idx] <= hit_line;
      end else if (state_q == ST_FILL && mem_ack) begin
         data_q[m_way][m_set] <= fill_line;
         tag_q[m_way][m_set]  <= m_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         for (int w = 0; w < WAYS; w++) begin
            valid_q[w] <= '0;
            dirty_q[w] <= '0;
         end
         m_set   <= '0;
         m_tag   <= '0;
         m_vtag  <= '0;
         m_way   <= '0;
         m_word  <= '0;
         m_we    <= 1'b0;
         m_wdata <= '0;
         m_be    <= '0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (tlb_fault) begin
                     err_q   <= 1'b1;
                     rdata_q <= '0;
                     state_q <= ST_RESP;
                  end else if (hit) begin
                     err_q   <= 1'b0;
                     rdata_q <= hit_line[int'(word_sel)*WORD_W +: WORD_W];
                     if (req_we) dirty_q[hit_way][set_idx] <= 1'b1;
                     state_q <= ST_RESP;
                  end else begin
                     err_q   <= 1'b0;
                     m_set   <= set_idx;
                     m_tag   <= look_tag;
                     m_vtag  <= tag_q[victim][set_idx];
                     m_way   <= victim;
                     m_word  <= word_sel;
                     m_we    <= req_we;
                     m_wdata <= req_wdata;
                     m_be    <= req_be;
                     state_q <= (valid_q[victim][set_idx] && dirty_q[victim][set_idx])
                                ? ST_WB : ST_FILL;
                  end
               end
            end
            ST_WB: begin
               if (mem_ack) state_q <= ST_FILL;
            end
            ST_FILL: begin
               if (mem_ack) begin
                  valid_q[m_way][m_set] <= 1'b1;
                  dirty_q[m_way][m_set] <= m_we;
                  rdata_q <= fill_line[int'(m_word)*WORD_W +: WORD_W];
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_busy   = (state_q != ST_IDLE) || (req_valid && !tlb_ready && !tlb_fault);
   assign tlb_lookup = req_valid && (state_q == ST_IDLE);
   assign rsp_valid  = (state_q == ST_RESP);
   assign rsp_err    = rsp_valid && err_q;
   assign rsp_rdata  = rdata_q;

   assign mem_req   = (state_q == ST_WB) || (state_q == ST_FILL);
   assign mem_we    = (state_q == ST_WB);
   assign mem_addr  = (state_q == ST_WB) ? LA_W'({m_vtag, m_set}) : LA_W'({m_tag, m_set});
   assign mem_wdata = data_q[m_way][m_set];
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
   parameter int LA_W = 26
)(
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_busy,
   input logic            rsp_valid,
   input logic            rsp_err,
   input logic            tlb_ready,
   input logic            tlb_fault,
   input logic            mem_req,
   input logic            mem_we,
   input logic            mem_ack,
   input logic [LA_W-1:0] mem_addr
);
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rsp_valid && !mem_req));

   a_r2_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !tlb_ready && !tlb_fault) |-> req_busy);

   a_r3_fault_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!mem_req && !$past(mem_req)));

   a_r4_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r7_hit_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(mem_ack)) |-> !$past(mem_req));

   a_r8_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   a_r11_fill_then_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> rsp_valid);
endmodule

bind vipt_cache vipt_cache_chk #(.LA_W(PA_W - $clog2(LINE_BYTES))) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_busy (req_busy),
   .rsp_valid(rsp_valid),
   .rsp_err  (rsp_err),
   .tlb_ready(tlb_ready),
   .tlb_fault(tlb_fault),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_ack  (mem_ack),
   .mem_addr (mem_addr)
);

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n;
   logic         req_valid, req_we;
   logic [31:2]  req_vaddr;
   logic [31:0]  req_wdata;
   logic [3:0]   req_be;
   logic         req_busy, rsp_valid, rsp_err;
   logic [31:0]  rsp_rdata;
   logic         tlb_lookup;
   logic [19:0]  tlb_vpn, tlb_pfn;
   logic         tlb_ready, tlb_fault;
   logic         mem_req, mem_we, mem_ack;
   logic [25:0]  mem_addr;
   logic [511:0] mem_wdata, mem_rdata;

   vipt_cache u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_we(req_we), .req_vaddr(req_vaddr),
      .req_wdata(req_wdata), .req_be(req_be),
      .req_busy(req_busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .tlb_lookup(tlb_lookup), .tlb_vpn(tlb_vpn), .tlb_ready(tlb_ready),
      .tlb_fault(tlb_fault), .tlb_pfn(tlb_pfn),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // TLB model: frame = low 16 bits of the page number, so pages 0x0xxxx and 0x1xxxx alias
   assign tlb_pfn = {4'h0, tlb_vpn[15:0]};

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int rd_cnt = 0, wb_cnt = 0, ack_cyc = 0;
   logic [25:0] last_wb_addr = '0;
   logic finished = 1'b0;
   logic [511:0] mem_store [int unsigned];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [511:0] init_line(input logic [25:0] la);
      logic [511:0] l;
      for (int w = 0; w < 16; w++) l[w*32 +: 32] = {la, w[3:0], 2'b00} ^ 32'h5EED0000;
      return l;
   endfunction

   // lower-level memory: acknowledges on the third falling edge of a request
   int wait_cnt = 0;
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
         end else if (mem_req) begin
            wait_cnt++;
            if (wait_cnt == 3) begin
               mem_ack = 1'b1;
               ack_cyc = cyc;
               if (mem_we) begin
                  mem_store[int'(mem_addr)] = mem_wdata;
                  wb_cnt++;
                  last_wb_addr = mem_addr;
               end else begin
                  rd_cnt++;
                  mem_rdata = mem_store.exists(int'(mem_addr)) ? mem_store[int'(mem_addr)]
                                                                : init_line(mem_addr);
               end
            end
         end
      end
   end

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one access; returns latency in cycles (0 on timeout)
   task automatic access(input logic we, input logic [31:0] va, input logic [31:0] wd,
                         input logic [3:0] be, output int lat, output logic [31:0] rd,
                         output logic err);
      req_valid = 1'b1; req_we = we; req_vaddr = va[31:2]; req_wdata = wd; req_be = be;
      lat = 0; rd = '0; err = 1'b0;
      for (int i = 1; i <= 100; i++) begin
         @(negedge clk);
         if (rsp_valid) begin
            lat = i; rd = rsp_rdata; err = rsp_err;
            break;
         end
      end
      req_valid = 1'b0;
      if (lat == 0) check(1'b0, "timeout", 32'd0, 32'd1);
   endtask

   typedef struct packed {
      logic        we;
      logic [31:0] va;
      logic [31:0] wd;
      logic [3:0]  be;
      logic        chk;
      logic [31:0] exp;
      logic        hit;
      logic        wb;
   } vec_t;

   // set 1 sequence exercises R5, R6, R10, R8; set 2 exercises R9
   localparam vec_t VECS [21] = '{
      '{1'b0, 32'h00001040, 32'h0,        4'h0, 1'b1, 32'h5EED1040, 1'b0, 1'b0}, // R1 cold miss
      '{1'b0, 32'h00001044, 32'h0,        4'h0, 1'b1, 32'h5EED1044, 1'b1, 1'b0}, // R4
      '{1'b1, 32'h00001048, 32'hAABBCCDD, 4'hF, 1'b0, 32'h0,        1'b1, 1'b0}, // R7
      '{1'b0, 32'h10001048, 32'h0,        4'h0, 1'b1, 32'hAABBCCDD, 1'b1, 1'b0}, // R5 alias
      '{1'b1, 32'h00002080, 32'h11112222, 4'h3, 1'b0, 32'h0,        1'b0, 1'b0}, // R9 alloc
      '{1'b0, 32'h00002080, 32'h0,        4'h0, 1'b1, 32'h5EED2222, 1'b1, 1'b0}, // R9 merge
      '{1'b0, 32'h00002040, 32'h0,        4'h0, 1'b1, 32'h5EED2040, 1'b0, 1'b0}, // R6
      '{1'b0, 32'h00003040, 32'h0,        4'h0, 1'b1, 32'h5EED3040, 1'b0, 1'b0}, // R6
      '{1'b0, 32'h00004040, 32'h0,        4'h0, 1'b1, 32'h5EED4040, 1'b0, 1'b0}, // R6 set full
      '{1'b0, 32'h0000104C, 32'h0,        4'h0, 1'b1, 32'h5EED104C, 1'b1, 1'b0}, // R6 all resident
      '{1'b0, 32'h00005040, 32'h0,        4'h0, 1'b1, 32'h5EED5040, 1'b0, 1'b0}, // R10 evicts p2
      '{1'b0, 32'h00002044, 32'h0,        4'h0, 1'b1, 32'h5EED2044, 1'b0, 1'b0}, // R10 p2 gone
      '{1'b0, 32'h00001048, 32'h0,        4'h0, 1'b1, 32'hAABBCCDD, 1'b1, 1'b0}, // R10 p1 kept
      '{1'b0, 32'h00006040, 32'h0,        4'h0, 1'b1, 32'h5EED6040, 1'b0, 1'b0},
      '{1'b0, 32'h00007040, 32'h0,        4'h0, 1'b1, 32'h5EED7040, 1'b0, 1'b0},
      '{1'b0, 32'h00008040, 32'h0,        4'h0, 1'b1, 32'h5EED8040, 1'b0, 1'b0},
      '{1'b0, 32'h00009040, 32'h0,        4'h0, 1'b1, 32'h5EED9040, 1'b0, 1'b1}, // R8 dirty p1 out
      '{1'b0, 32'h00001048, 32'h0,        4'h0, 1'b1, 32'hAABBCCDD, 1'b0, 1'b0}, // R8 data kept below
      '{1'b0, 32'h00003040, 32'h0,        4'h0, 1'b1, 32'h5EED3040, 1'b0, 1'b0},
      '{1'b0, 32'h00008040, 32'h0,        4'h0, 1'b1, 32'h5EED8040, 1'b1, 1'b0}, // R10 p8 kept
      '{1'b0, 32'h00006040, 32'h0,        4'h0, 1'b1, 32'h5EED6040, 1'b0, 1'b0}  // R10 p6 evicted
   };

   initial begin
      int lat;
      logic [31:0] rd;
      logic err;
      int rd0, wb0;
      rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_vaddr = '0;
      req_wdata = '0; req_be = '0; tlb_ready = 1'b1; tlb_fault = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!rsp_valid && !mem_req && !req_busy, "R1 reset outputs",
            {29'd0, rsp_valid, mem_req, req_busy}, 32'd0);

      for (int i = 0; i < 21; i++) begin
         rd0 = rd_cnt; wb0 = wb_cnt;
         access(VECS[i].we, VECS[i].va, VECS[i].wd, VECS[i].be, lat, rd, err);
         if (VECS[i].hit) begin
            check(lat == 1, "R4 hit latency", lat, 1);
            check(rd_cnt == rd0 && wb_cnt == wb0, "R7 hit no memory traffic",
                  rd_cnt + wb_cnt, rd0 + wb0);
         end else begin
            check(rd_cnt == rd0 + 1, "R6 miss reads one line", rd_cnt, rd0 + 1);
            check(wb_cnt == wb0 + int'(VECS[i].wb), "R8 write-back count",
                  wb_cnt, wb0 + int'(VECS[i].wb));
            check(cyc == ack_cyc + 1, "R11 response after fill", cyc, ack_cyc + 1);
         end
         if (VECS[i].chk) check(rd == VECS[i].exp, "R9/R10 read data", rd, VECS[i].exp);
         check(!err, "R3 no error on good translation", {31'd0, err}, 32'd0);
         if (VECS[i].wb) check(last_wb_addr == 26'h41, "R8 write-back address",
                               {6'd0, last_wb_addr}, 32'h41);
         @(negedge clk);
      end

      // R2: translation pending stalls
      tlb_ready = 1'b0;
      req_valid = 1'b1; req_we = 1'b0; req_vaddr = 30'h00001048 >> 2; req_be = '0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(req_busy && !rsp_valid && !mem_req, "R2 stall",
               {29'd0, req_busy, rsp_valid, mem_req}, 32'h4);
      end
      tlb_ready = 1'b1;
      @(negedge clk);
      check(rsp_valid && rsp_rdata == 32'hAABBCCDD, "R2 resume hit", rsp_rdata, 32'hAABBCCDD);
      req_valid = 1'b0;
      @(negedge clk);

      // R3: fault write leaves the line unchanged
      tlb_ready = 1'b0; tlb_fault = 1'b1;
      rd0 = rd_cnt; wb0 = wb_cnt;
      access(1'b1, 32'h00001048, 32'h0, 4'hF, lat, rd, err);
      check(err && lat == 1, "R3 fault response", {31'd0, err}, 32'd1);
      check(rd_cnt == rd0 && wb_cnt == wb0, "R3 fault no memory traffic",
            rd_cnt + wb_cnt, rd0 + wb0);
      tlb_ready = 1'b1; tlb_fault = 1'b0;
      @(negedge clk);
      access(1'b0, 32'h00001048, 32'h0, 4'h0, lat, rd, err);
      check(rd == 32'hAABBCCDD && lat == 1, "R3 cache unchanged", rd, 32'hAABBCCDD);
      @(negedge clk);

      // R7: single-byte write hit
      wb0 = wb_cnt;
      access(1'b1, 32'h0000104C, 32'h12345678, 4'h8, lat, rd, err);
      @(negedge clk);
      access(1'b0, 32'h0000104C, 32'h0, 4'h0, lat, rd, err);
      check(rd == 32'h12ED104C, "R7 byte merge", rd, 32'h12ED104C);
      check(wb_cnt == wb0, "R7 no write-through", wb_cnt, wb0);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule